// File: doc/BRIEF.md
# Byte-Wise Table-Driven CRC-16 Divider

This block divides a byte stream by the generator x^16 + x^12 + x^5 + 1 and reports the 16-bit remainder. It takes one byte per clock. The remainder sits in a high byte and a low byte. Each step reads one 16-bit entry from a 256-entry lookup, indexed by the high byte. That entry is XORed with the low byte and the incoming byte placed side by side. No register is preset and no output mask is applied. The result is the plain remainder of the message polynomial. The lookup is computed at elaboration by a constant function, so nothing is loaded from outside.

A frame is offered on a valid/ready input. The byte that opens a frame carries a start marker and the byte that closes it carries an end marker. In generate mode, the block appends two zero bytes on its own after the closing byte. The remainder it then reports is the check code to send. In check mode, the bytes are taken as they arrive. When a frame and its appended check code are passed in check mode, a zero remainder shows the frame is intact. When the frame ends, the block raises a done flag, presents the remainder, and raises a zero flag if that remainder is zero. These outputs hold until the next frame starts.

Top module: `crc_bytestream_divider`

## Requirements
- R1: Each lookup entry for index a equals the remainder of the three-byte value [a, 0x00, 0x00] divided by 0x1_1021. The entries include 0x00→0x0000, 0x01→0x1021, 0x02→0x2042, 0x08→0x8108, 0x0F→0xF1EF, 0x10→0x1231, 0x11→0x0210 and 0x20→0x2462. A check-mode frame [a, 0, 0] therefore reports that entry.
- R2: There is no preset. A one-byte frame b reports 0x00bb. A two-byte frame [b1, b2] reports {b1, b2}.
- R3: From the third byte on, each accepted byte m updates the remainder {h, l} to entry[h] XOR {l, m}. After the frame, crc_out equals the remainder of the whole byte sequence taken MSB first.
- R4: In check mode (encode_mode = 0 when the start byte is accepted), done is high in the cycle after the edge that accepts the end byte. in_ready stays high throughout.
- R5: In generate mode (encode_mode = 1 when the start byte is accepted), in_ready is low for exactly two cycles after the end byte is accepted. During those cycles two zero bytes are divided in. done rises in the third cycle. encode_mode is sampled only with the start byte.
- R6: zero_ok is high only while done is high and crc_out is 0x0000. A check-mode frame made of the data followed by its generated check code (high byte first) reports zero_ok = 1. The same frame with one bit flipped reports zero_ok = 0.
- R7: While done is high, bytes offered without the start marker are ignored: done, crc_out and zero_ok do not change until a start byte is accepted.
- R8: A start byte accepted in the middle of a frame abandons that frame and begins a new one from that byte.
- R9: After reset, done = 0, zero_ok = 0, in_ready = 1 and crc_out = 0x0000.
- R10: Cycles with in_valid low do not change the result. A frame offered with idle gaps reports the same remainder as the same frame without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| encode_mode | input | 1 | 1 = append two zero bytes (generate), 0 = check; sampled with the start byte |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken; low while zero bytes are appended |
| in_data | input | 8 | Message byte, MSB first |
| in_first | input | 1 | Byte opens a frame |
| in_last | input | 1 | Byte closes a frame |
| done | output | 1 | Frame finished, result valid |
| crc_out | output | 16 | Remainder {high, low} |
| zero_ok | output | 1 | done and remainder is zero |

## Verification
The properties assume that in_data, in_first, in_last and encode_mode hold steady while in_valid is high and in_ready is low. They also assume that a frame opens with a start byte before any end byte counts. The bench changes its inputs only on falling edges. It keeps a byte on the bus until in_ready is seen high, and it starts every frame with a marked byte. The single-byte property in the checker depends on in_data being stable across the accepting edge, and this discipline keeps it so.

// File: rtl/crcdiv_pkg.sv
package crcdiv_pkg;
  localparam int BYTE_W = 8;
  localparam int REM_W  = 2 * BYTE_W;
  localparam int LUT_N  = 1 << BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RUN  = 3'd1,
    PH_PAD0 = 3'd2,
    PH_PAD1 = 3'd3,
    PH_DONE = 3'd4
  } phase_t;

  // Remainder of {idx, zero byte, zero byte} modulo x^16 + poly
  function automatic logic [REM_W-1:0] lut_entry(input logic [BYTE_W-1:0] idx,
                                                 input logic [REM_W-1:0]  poly);
    logic [REM_W-1:0] acc;
    acc = {idx, {BYTE_W{1'b0}}};
    for (int s = 0; s < BYTE_W; s++) begin
      if (acc[REM_W-1]) acc = (acc << 1) ^ poly;
      else              acc = acc << 1;
    end
    return acc;
  endfunction
endpackage

// File: rtl/crcdiv_rstsync.sv
module crcdiv_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_n_sync = pipe_q[1];
endmodule

// File: rtl/crcdiv_lut.sv
module crcdiv_lut
  import crcdiv_pkg::*;
#(
  parameter logic [REM_W-1:0] POLY = 16'h1021
) (
  input  logic [BYTE_W-1:0] idx,
  output logic [REM_W-1:0]  entry
);
  logic [REM_W-1:0] rom [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_rom
    assign rom[g] = lut_entry(BYTE_W'(g), POLY);
  end

  assign entry = rom[idx];
endmodule

// File: rtl/crcdiv_seq.sv
module crcdiv_seq
  import crcdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic encode_mode,
  input  logic in_valid,
  input  logic in_first,
  input  logic in_last,
  output logic in_ready,
  output logic done,
  output logic load_first,
  output logic step_in,
  output logic step_pad
);
  phase_t phase_q, phase_n;
  logic   mode_q, mode_n;
  logic   accept;

  assign in_ready = (phase_q != PH_PAD0) && (phase_q != PH_PAD1);
  assign accept   = in_valid && in_ready;
  assign done     = (phase_q == PH_DONE);

  assign load_first = accept && in_first;
  assign step_in    = accept && !in_first && (phase_q == PH_RUN);
  assign step_pad   = (phase_q == PH_PAD0) || (phase_q == PH_PAD1);

  always_comb begin
    phase_n = phase_q;
    mode_n  = mode_q;
    if (load_first) begin
      mode_n = encode_mode;
      if (in_last) phase_n = encode_mode ? PH_PAD0 : PH_DONE;
      else         phase_n = PH_RUN;
    end else begin
      case (phase_q)
        PH_RUN:  if (accept && in_last) phase_n = mode_q ? PH_PAD0 : PH_DONE;
        PH_PAD0: phase_n = PH_PAD1;
        PH_PAD1: phase_n = PH_DONE;
        default: phase_n = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      mode_q  <= mode_n;
    end
  end
endmodule

// File: rtl/crcdiv_rem.sv
module crcdiv_rem
  import crcdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic              step_in,
  input  logic              step_pad,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [REM_W-1:0]  entry,
  output logic [BYTE_W-1:0] lut_idx,
  output logic [REM_W-1:0]  rem
);
  logic [REM_W-1:0]  rem_q, rem_n;
  logic [BYTE_W-1:0] feed;
  logic              rem_en;

  assign feed    = step_pad ? {BYTE_W{1'b0}} : byte_in;
  assign rem_en  = load_first || step_in || step_pad;
  assign lut_idx = rem_q[REM_W-1:BYTE_W];

  always_comb begin
    if (load_first) rem_n = {{BYTE_W{1'b0}}, byte_in};
    else            rem_n = entry ^ {rem_q[BYTE_W-1:0], feed};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_n;
  end

  assign rem = rem_q;
endmodule

// File: rtl/crc_bytestream_divider.sv
module crc_bytestream_divider
  import crcdiv_pkg::*;
#(
  parameter logic [REM_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              encode_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              done,
  output logic [REM_W-1:0]  crc_out,
  output logic              zero_ok
);
  logic              rst_n_sync;
  logic              load_first, step_in, step_pad;
  logic [BYTE_W-1:0] lut_idx;
  logic [REM_W-1:0]  entry;
  logic [REM_W-1:0]  rem;

  crcdiv_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  crcdiv_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .encode_mode (encode_mode),
    .in_valid    (in_valid),
    .in_first    (in_first),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .done        (done),
    .load_first  (load_first),
    .step_in     (step_in),
    .step_pad    (step_pad)
  );

  crcdiv_lut #(.POLY(POLY)) u_lut (
    .idx   (lut_idx),
    .entry (entry)
  );

  crcdiv_rem u_rem (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load_first (load_first),
    .step_in    (step_in),
    .step_pad   (step_pad),
    .byte_in    (in_data),
    .entry      (entry),
    .lut_idx    (lut_idx),
    .rem        (rem)
  );

  assign crc_out = rem;
  assign zero_ok = done && (rem == '0);
endmodule

// File: rtl/crcdiv_checker.sv
module crcdiv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        encode_mode,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        in_first,
  input logic        in_last,
  input logic        done,
  input logic [15:0] crc_out,
  input logic        zero_ok
);
  p_done_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ok |-> (done && crc_out == 16'h0000));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(in_valid && in_first)) |=> (done && $stable(crc_out)));

  p_single_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_first && in_last && !encode_mode)
      |=> (done && crc_out == {8'h00, $past(in_data)}));

  p_pad_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_first && in_last && encode_mode) |=> !in_ready);

  p_pad_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |=> (in_ready && done));
endmodule

bind crc_bytestream_divider crcdiv_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .encode_mode (encode_mode),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .in_first    (in_first),
  .in_last     (in_last),
  .done        (done),
  .crc_out     (crc_out),
  .zero_ok     (zero_ok)
);

// File: tb/crc_bytestream_divider_test.sv
module crc_bytestream_divider_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        encode_mode;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_first;
  logic        in_last;
  logic        done;
  logic [15:0] crc_out;
  logic        zero_ok;

  int checks;
  int errors;
  bit finished;

  logic [7:0]  msg [0:63];
  int          lat_q;
  int          lowcnt_q;
  logic [15:0] lfsr;

  crc_bytestream_divider uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .encode_mode (encode_mode),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .in_first    (in_first),
    .in_last     (in_last),
    .done        (done),
    .crc_out     (crc_out),
    .zero_ok     (zero_ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_rem(input int n, input bit pad);
    logic [15:0] r;
    logic [7:0]  b;
    bit          fb;
    r = 16'h0000;
    for (int i = 0; i < n + (pad ? 2 : 0); i++) begin
      b = (i < n) ? msg[i] : 8'h00;
      for (int k = 7; k >= 0; k--) begin
        fb = r[15];
        r  = {r[14:0], b[k]};
        if (fb) r = r ^ 16'h1021;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  // Drive msg[0..n-1]; gap>0 inserts one idle cycle before every gap-th byte.
  task automatic run_frame(input int n, input bit enc, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hA5;
        in_last  = 1'b1;
      end
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = msg[i];
      in_first    = (i == 0);
      in_last     = (i == n - 1);
      encode_mode = (i == 0) ? enc : !enc;
      while (!in_ready) @(negedge clk);
    end
    lat_q    = 0;
    lowcnt_q = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      in_last  = 1'b0;
      lat_q++;
      if (!in_ready) lowcnt_q++;
      if (done) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual expired expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    lfsr = 16'hACE1;
    rst_n = 1'b0; encode_mode = 1'b0; in_valid = 1'b0;
    in_data = 8'h00; in_first = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk(done == 1'b0, "R9 done", {15'd0, done}, 16'h0);
    chk(zero_ok == 1'b0, "R9 zero_ok", {15'd0, zero_ok}, 16'h0);
    chk(in_ready == 1'b1, "R9 in_ready", {15'd0, in_ready}, 16'h1);
    chk(crc_out == 16'h0000, "R9 crc_out", crc_out, 16'h0000);

    // R1 sweep of every lookup index through frame [a,0,0]
    for (int a = 0; a < 256; a++) begin
      logic [15:0] spot;
      bit          has_spot;
      msg[0] = 8'(a); msg[1] = 8'h00; msg[2] = 8'h00;
      run_frame(3, 1'b0, 0);
      chk(done && crc_out == ref_rem(3, 0), "R1 entry", crc_out, ref_rem(3, 0));
      chk(lat_q == 1 && lowcnt_q == 0, "R4 check-mode latency", 16'(lat_q), 16'd1);
      has_spot = 1'b1;
      case (a)
        8'h00: spot = 16'h0000;  8'h01: spot = 16'h1021;
        8'h02: spot = 16'h2042;  8'h08: spot = 16'h8108;
        8'h0F: spot = 16'hF1EF;  8'h10: spot = 16'h1231;
        8'h11: spot = 16'h0210;  8'h20: spot = 16'h2462;
        default: begin spot = 16'h0; has_spot = 1'b0; end
      endcase
      if (has_spot) chk(crc_out == spot, "R1 listed entry", crc_out, spot);
    end

    // R2 one and two byte frames load directly
    for (int b = 0; b < 256; b += 17) begin
      msg[0] = 8'(b);
      run_frame(1, 1'b0, 0);
      chk(crc_out == {8'h00, 8'(b)}, "R2 one byte", crc_out, {8'h00, 8'(b)});
      msg[0] = 8'(b); msg[1] = 8'(255 - b);
      run_frame(2, 1'b0, 0);
      chk(crc_out == {8'(b), 8'(255 - b)}, "R2 two bytes", crc_out, {8'(b), 8'(255 - b)});
    end

    // R3 / R10 random frames, with and without idle gaps
    for (int f = 0; f < 40; f++) begin
      int n;
      n = 3 + (f % 18);
      for (int i = 0; i < n; i++) msg[i] = next_rand();
      run_frame(n, 1'b0, 0);
      chk(crc_out == ref_rem(n, 0), "R3 update", crc_out, ref_rem(n, 0));
      run_frame(n, 1'b0, 1 + (f % 3));
      chk(crc_out == ref_rem(n, 0), "R10 gaps", crc_out, ref_rem(n, 0));
    end

    // R5 generate mode, R6 round trip and corruption
    for (int f = 0; f < 24; f++) begin
      int          n;
      logic [15:0] code;
      n = 1 + (f % 16);
      for (int i = 0; i < n; i++) msg[i] = next_rand();
      run_frame(n, 1'b1, f % 2);
      code = ref_rem(n, 1);
      chk(crc_out == code, "R5 check code", crc_out, code);
      chk(lowcnt_q == 2, "R5 ready low cycles", 16'(lowcnt_q), 16'd2);
      chk(lat_q == 3, "R5 done latency", 16'(lat_q), 16'd3);
      msg[n] = code[15:8]; msg[n+1] = code[7:0];
      run_frame(n + 2, 1'b0, 0);
      chk(zero_ok == 1'b1 && crc_out == 16'h0, "R6 accept", crc_out, 16'h0000);
      msg[f % n] = msg[f % n] ^ 8'(1 << (f % 8));
      run_frame(n + 2, 1'b0, 0);
      chk(zero_ok == 1'b0 && crc_out != 16'h0, "R6 reject", {15'd0, zero_ok}, 16'h0);
    end

    // R7 non-start bytes while done are ignored
    for (int i = 0; i < 5; i++) msg[i] = next_rand();
    run_frame(5, 1'b0, 0);
    begin
      logic [15:0] held;
      held = crc_out;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b0; in_last = c[0]; in_data = next_rand();
        @(negedge clk);
        chk(done && crc_out == held && zero_ok == (held == 16'h0), "R7 hold",
            crc_out, held);
      end
      in_valid = 1'b0; in_last = 1'b0;
    end

    // R8 restart in the middle of a frame
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 3 + r; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = next_rand();
        in_first = (i == 0); in_last = 1'b0; encode_mode = r[0];
      end
      for (int i = 0; i < 6; i++) msg[i] = next_rand();
      run_frame(6, r[1], 0);
      chk(crc_out == ref_rem(6, r[1]), "R8 restart", crc_out, ref_rem(6, r[1]));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule